// File: doc/BRIEF.md
# Blocked Memory Row/Column Repair Steering

This block sits between a memory access port and a 32K-word by 32-bit array that is laid out as four blocks of 512 rows by 512 bit-columns (two block columns side by side, two block rows stacked). It holds four repair registers, each with an enable bit and a fault-group address. Two registers steer spare rows and two steer spare columns, with one of each per half of the row range. For every access it decides, in the same cycle, whether the addressed rows or columns have been replaced. It then drives steering selects for the array's spare rows and spare column lanes.

Spare rows replace an aligned group of 8 rows as a unit, so a row register holds `row[9:3]`. Spare columns replace an aligned group of 4 bit-columns as a unit, so a column register holds the physical column divided by 4. The registers are loaded through a plain parallel write port, and reset clears every enable.

The access address is 15 bits: `accAddr[14:5]` is the row (0..1023), `accAddr[4]` is the block column (0 = columns 0..511, 1 = columns 512..1023) and `accAddr[3:0]` is the word select (0..15). Data bit d of a word at block column b and word select s sits on physical column `b*512 + s*32 + d`.

Top module: `rsteer_top`

## Requirements
- R1: While reset is high and in the first cycle after it, all four repair enables are clear, so `rowSpareSel`, `colSpareSel`, `bothHit` and `colLaneMask` are 0 for every address.
- R2: If the row register of half h (h = `accAddr[14]`) is enabled and its 7-bit field equals `accAddr[14:8]`, then `rowSpareSel`=1, `rowSpareIdx`=`accAddr[7:5]` and `spareHalf`=h.
- R3: If the column register of half h is enabled and bits [7:3] of its 8-bit field equal `accAddr[4:0]`, a column hit occurs. When no row hit occurs, `colSpareSel`=1 and `colLaneMask` is one-hot at bit k = field[2:0]. Lane k carries data bits 4k..4k+3. Otherwise `colLaneMask`=0.
- R4: A register only affects accesses in its own row half (rows 0..511 for h=0, rows 512..1023 for h=1). A lower-half row register whose field has bit 6 set never matches.
- R5: A register whose enable bit is 0 never causes substitution, whatever its address field holds.
- R6: All outputs are combinational from `accAddr` and the stored registers, and are valid in the same cycle as the access.
- R7: When a row hit and a column hit occur together, the row spare wins. `rowSpareSel`=1, `colSpareSel`=0, `colLaneMask`=0 and `bothHit`=1. Otherwise `bothHit`=0.
- R8: A write with `wrEn`=1 loads `wrEnable` and `wrFault` into the register chosen by `wrKind` (0 = row, taking `wrFault[6:0]`; 1 = column, taking all 8 bits) and `wrHalf`. The new contents affect outputs from the cycle after the write edge, not during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Repair register write strobe |
| wrKind | input | 1 | 0 = row register, 1 = column register |
| wrHalf | input | 1 | Row half the register belongs to |
| wrEnable | input | 1 | Enable bit to load |
| wrFault | input | 8 | Fault group address to load |
| accAddr | input | 15 | Access address {row, block column, word select} |
| rowSpareSel | output | 1 | Use the spare row group |
| rowSpareIdx | output | 3 | Row within the spare group |
| colSpareSel | output | 1 | Use the spare column lane |
| colLaneMask | output | 8 | One-hot data lane replaced by spare columns |
| spareHalf | output | 1 | Row half whose spares are selected |
| bothHit | output | 1 | Row and column repairs both matched |

## Verification
A row repair and a column repair can both match one access. This happens when the upper-half row register and the upper-half column register are aimed at the same row group and word. The bench builds exactly that case and also lets it arise in a long pseudo-random phase, where accesses are often drawn from the stored column faults. It judges the row-priority outcome and `bothHit` against a behavioural reference on every cycle. A register write landing in the same cycle as a matching access is the other overlap. The bench checks that the old contents still steer during that cycle.

// File: rtl/rsteer_pkg.sv
package rsteer_pkg;
  localparam int ROW_W    = 10;
  localparam int CBLK_W   = 1;
  localparam int COLSEL_W = 4;
  localparam int DATA_W   = 32;
  localparam int COL_GRP  = 4;
  localparam int ROW_GRP  = 8;
  localparam int HALVES   = 2;

  localparam int HALF_W   = $clog2(HALVES);
  localparam int ADDR_W   = ROW_W + CBLK_W + COLSEL_W;
  localparam int WCOL_W   = CBLK_W + COLSEL_W;
  localparam int PCOL_W   = WCOL_W + $clog2(DATA_W);
  localparam int CGRP_W   = PCOL_W - $clog2(COL_GRP);
  localparam int LANES    = DATA_W / COL_GRP;
  localparam int LANE_W   = CGRP_W - WCOL_W;
  localparam int RIDX_W   = $clog2(ROW_GRP);
  localparam int RGRP_W   = ROW_W - RIDX_W;
  localparam int FAULT_W  = (CGRP_W > RGRP_W) ? CGRP_W : RGRP_W;

  typedef struct packed {
    logic [HALVES-1:0]  loadRow;
    logic [HALVES-1:0]  loadCol;
    logic               enBit;
    logic [FAULT_W-1:0] fault;
  } wrStrobe_t;
endpackage

// File: rtl/rsteer_ctrl.sv
module rsteer_ctrl
  import rsteer_pkg::*;
(
  input  logic               wrEn,
  input  logic               wrKind,
  input  logic [HALF_W-1:0]  wrHalf,
  input  logic               wrEnable,
  input  logic [FAULT_W-1:0] wrFault,
  output wrStrobe_t          strobe
);
  always_comb begin
    strobe = '0;
    strobe.enBit = wrEnable;
    strobe.fault = wrFault;
    for (int h = 0; h < HALVES; h++) begin
      if (wrEn && (wrHalf == HALF_W'(h))) begin
        if (wrKind) strobe.loadCol[h] = 1'b1;
        else        strobe.loadRow[h] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsteer_dp.sv
module rsteer_dp
  import rsteer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              rowSpareSel,
  output logic [RIDX_W-1:0] rowSpareIdx,
  output logic              colSpareSel,
  output logic [LANES-1:0]  colLaneMask,
  output logic [HALF_W-1:0] spareHalf,
  output logic              bothHit
);
  logic [HALVES-1:0]             rowEn;
  logic [HALVES-1:0][RGRP_W-1:0] rowFault;
  logic [HALVES-1:0]             colEn;
  logic [HALVES-1:0][CGRP_W-1:0] colFault;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowEn    <= '0;
      rowFault <= '0;
      colEn    <= '0;
      colFault <= '0;
    end else begin
      for (int h = 0; h < HALVES; h++) begin
        if (strobe.loadRow[h]) begin
          rowEn[h]    <= strobe.enBit;
          rowFault[h] <= strobe.fault[RGRP_W-1:0];
        end
        if (strobe.loadCol[h]) begin
          colEn[h]    <= strobe.enBit;
          colFault[h] <= strobe.fault[CGRP_W-1:0];
        end
      end
    end
  end

  logic [ROW_W-1:0]  rowNum;
  logic [HALF_W-1:0] halfIdx;
  logic [RGRP_W-1:0] rowGrp;
  logic [WCOL_W-1:0] wordCol;
  logic [CGRP_W-1:0] selColFault;
  logic              rowHit;
  logic              colHit;

  assign rowNum      = accAddr[ADDR_W-1 -: ROW_W];
  assign halfIdx     = rowNum[ROW_W-1 -: HALF_W];
  assign rowGrp      = rowNum[ROW_W-1:RIDX_W];
  assign wordCol     = accAddr[WCOL_W-1:0];
  assign selColFault = colFault[halfIdx];

  assign rowHit = rowEn[halfIdx] && (rowFault[halfIdx] == rowGrp);
  assign colHit = colEn[halfIdx] && (selColFault[CGRP_W-1:LANE_W] == wordCol);

  assign rowSpareSel = rowHit;
  assign rowSpareIdx = rowNum[RIDX_W-1:0];
  assign colSpareSel = colHit && !rowHit;
  assign bothHit     = colHit && rowHit;
  assign spareHalf   = (rowHit || colHit) ? halfIdx : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign colLaneMask[l] = colSpareSel && (selColFault[LANE_W-1:0] == LANE_W'(l));
  end
endmodule

// File: rtl/rsteer_top.sv
module rsteer_top
  import rsteer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic               wrKind,
  input  logic [HALF_W-1:0]  wrHalf,
  input  logic               wrEnable,
  input  logic [FAULT_W-1:0] wrFault,
  input  logic [ADDR_W-1:0]  accAddr,
  output logic               rowSpareSel,
  output logic [RIDX_W-1:0]  rowSpareIdx,
  output logic               colSpareSel,
  output logic [LANES-1:0]   colLaneMask,
  output logic [HALF_W-1:0]  spareHalf,
  output logic               bothHit
);
  wrStrobe_t strobe;

  rsteer_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrKind   (wrKind),
    .wrHalf   (wrHalf),
    .wrEnable (wrEnable),
    .wrFault  (wrFault),
    .strobe   (strobe)
  );

  rsteer_dp u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .accAddr     (accAddr),
    .rowSpareSel (rowSpareSel),
    .rowSpareIdx (rowSpareIdx),
    .colSpareSel (colSpareSel),
    .colLaneMask (colLaneMask),
    .spareHalf   (spareHalf),
    .bothHit     (bothHit)
  );
endmodule

// File: rtl/rsteer_checker.sv
module rsteer_checker
  import rsteer_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [RIDX_W-1:0] rowBitsIn,
  input logic [HALF_W-1:0] halfBitsIn,
  input logic              rowSpareSel,
  input logic [RIDX_W-1:0] rowSpareIdx,
  input logic              colSpareSel,
  input logic [LANES-1:0]  colLaneMask,
  input logic [HALF_W-1:0] spareHalf,
  input logic              bothHit
);
  // R1: nothing is steered in the first cycle after reset
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rowSpareSel && !colSpareSel && !bothHit && colLaneMask == '0));

  // R2: spare row index follows the low row bits
  a_r2_row_index: assert property (@(posedge clk) disable iff (rst)
    rowSpareSel |-> (rowSpareIdx == rowBitsIn));

  // R3: exactly one lane when a column spare is used, none otherwise
  a_r3_lane_onehot: assert property (@(posedge clk) disable iff (rst)
    colSpareSel ? ($countones(colLaneMask) == 1) : (colLaneMask == '0));

  // R4: selected spares belong to the accessed row half
  a_r4_own_half: assert property (@(posedge clk) disable iff (rst)
    (rowSpareSel || colSpareSel) |-> (spareHalf == halfBitsIn));

  // R7: row spare wins and both-hit implies a row hit
  a_r7_row_wins: assert property (@(posedge clk) disable iff (rst)
    rowSpareSel |-> !colSpareSel);

  a_r7_both_flag: assert property (@(posedge clk) disable iff (rst)
    bothHit |-> rowSpareSel);
endmodule

bind rsteer_top rsteer_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .rowBitsIn   (accAddr[rsteer_pkg::WCOL_W + rsteer_pkg::RIDX_W - 1 : rsteer_pkg::WCOL_W]),
  .halfBitsIn  (accAddr[rsteer_pkg::ADDR_W-1 -: rsteer_pkg::HALF_W]),
  .rowSpareSel (rowSpareSel),
  .rowSpareIdx (rowSpareIdx),
  .colSpareSel (colSpareSel),
  .colLaneMask (colLaneMask),
  .spareHalf   (spareHalf),
  .bothHit     (bothHit)
);

// File: tb/rsteer_top_tb_top.sv
module rsteer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        wrKind = 1'b0;
  logic [0:0]  wrHalf = '0;
  logic        wrEnable = 1'b0;
  logic [7:0]  wrFault = '0;
  logic [14:0] accAddr = '0;
  logic        rowSpareSel;
  logic [2:0]  rowSpareIdx;
  logic        colSpareSel;
  logic [7:0]  colLaneMask;
  logic [0:0]  spareHalf;
  logic        bothHit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit mRowEn[2];
  int mRowFault[2];
  bit mColEn[2];
  int mColFault[2];

  always #10 clk = ~clk;

  rsteer_top dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrKind(wrKind), .wrHalf(wrHalf),
    .wrEnable(wrEnable), .wrFault(wrFault), .accAddr(accAddr),
    .rowSpareSel(rowSpareSel), .rowSpareIdx(rowSpareIdx), .colSpareSel(colSpareSel),
    .colLaneMask(colLaneMask), .spareHalf(spareHalf), .bothHit(bothHit)
  );

  function automatic int mk(int row, int cblk, int wsel);
    return (row << 5) | (cblk << 4) | wsel;
  endfunction

  // {rowSel, rowIdx[3], colSel, mask[8], half, both}
  function automatic logic [14:0] expect_out(int a);
    int row = a >> 5;
    int h = row / 512;
    int wcol = a & 31;
    bit rh = mRowEn[h] && (mRowFault[h] == row / 8);
    bit ch = mColEn[h] && ((mColFault[h] / 8) == wcol);
    logic [7:0] mask = (ch && !rh) ? 8'(1 << (mColFault[h] % 8)) : 8'h00;
    logic [2:0] idx = 3'(row % 8);
    bit hf = (rh || ch) ? h[0] : 1'b0;
    return {rh, idx, ch && !rh, mask, hf, rh && ch};
  endfunction

  task automatic check_now(string tag);
    logic [14:0] got = {rowSpareSel, rowSpareIdx, colSpareSel, colLaneMask, spareHalf, bothHit};
    logic [14:0] exp = expect_out(int'(accAddr));
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, accAddr, got, exp);
    end
  endtask

  // drive after a falling edge, check before the rising edge, then update model
  task automatic step(string tag, int a, bit we = 0, bit kind = 0, int half = 0,
                      bit en = 0, int fault = 0);
    accAddr = 15'(a);
    wrEn = we; wrKind = kind; wrHalf = 1'(half); wrEnable = en; wrFault = 8'(fault);
    #5;
    check_now(tag);
    @(posedge clk);
    if (we && !rst) begin
      if (kind) begin mColEn[half] = en; mColFault[half] = fault; end
      else begin mRowEn[half] = en; mRowFault[half] = fault % 128; end
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr(bit kind, int half, bit en, int fault);
    step("R8", mk(1000, 1, 15), 1, kind, half, en, fault);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int h = 0; h < 2; h++) begin
      mRowEn[h] = 0; mColEn[h] = 0; mRowFault[h] = 0; mColFault[h] = 0;
    end
    @(negedge clk);
    // R1: writes during reset are ignored, outputs idle
    step("R1", mk(43, 0, 0), 1, 0, 0, 1, 5);
    step("R1", mk(600, 1, 3), 1, 1, 1, 1, 154);
    rst = 1'b0;
    step("R1", mk(43, 0, 0));
    step("R1", mk(600, 1, 3));

    // R8: write cycle still sees old contents
    step("R8", mk(43, 0, 0), 1, 0, 0, 1, 5);
    step("R2", mk(43, 1, 7));
    step("R2", mk(40, 0, 0));
    step("R2", mk(48, 0, 0));
    step("R4", mk(555, 0, 0));

    // R3 column lane
    wr(1, 1, 1, 154);
    step("R3", mk(600, 1, 3));
    step("R3", mk(600, 1, 2));
    step("R3", mk(1023, 1, 3));
    step("R4", mk(100, 1, 3));

    // R6: two addresses within one cycle
    accAddr = 15'(mk(600, 1, 3)); #3; check_now("R6");
    accAddr = 15'(mk(43, 0, 0));  #3; check_now("R6");
    @(negedge clk);

    // R5: disabled register with matching address
    wr(1, 1, 0, 154);
    step("R5", mk(600, 1, 3));
    wr(0, 0, 0, 5);
    step("R5", mk(43, 0, 0));

    // R7: both hit in the upper half
    wr(1, 1, 1, 154);
    wr(0, 1, 1, 70);
    step("R7", mk(563, 1, 3));
    step("R7", mk(563, 0, 0));
    step("R7", mk(600, 1, 3));

    // R4: lower row register aimed beyond its half
    wr(0, 0, 1, 70);
    step("R4", mk(48, 0, 0));
    step("R4", mk(560, 1, 3));

    // mixed pseudo-random phase
    for (int i = 0; i < 400; i++) begin
      int a;
      int h = $urandom_range(1, 0);
      if ($urandom_range(1, 0) == 1)
        a = mk(h * 512 + $urandom_range(511, 0), mColFault[h] / 128, (mColFault[h] / 8) % 16);
      else
        a = int'($urandom_range(32767, 0));
      if ($urandom_range(3, 0) == 0)
        step("R7", a, 1, 1'($urandom_range(1, 0)), $urandom_range(1, 0),
             1'($urandom_range(3, 0) != 0), $urandom_range(255, 0));
      else
        step("R3", a);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule